// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block caches page-to-frame translations for a processor's address path. It holds a small set of fully associative entries, each carrying a process identifier, a page number and a frame number. A requester presents a page number together with the identifier of the running process. When a valid entry matches both fields, the frame number comes back combinationally in the same cycle and the lookup is accepted.

When no entry matches, the lookup is held back. The block reads the page table in main memory at the table base plus the page number, through a one-cycle request and a response of any latency. It writes the returned translation into a free entry, or into the entry under a round-robin pointer when every entry is valid. The held lookup then hits. A flush input and reset both discard every cached translation.

Top module: `pid_tlb`

## Requirements
- R1: With `lk_valid` high, the walker idle and a valid entry matching both `cur_pid` and `lk_page`, `lk_ready` is high in the same cycle and `lk_frame` carries that entry's frame. `lk_ready` is never high without `lk_valid`.
- R2: A valid entry whose page matches but whose process identifier differs from `cur_pid` does not produce a hit.
- R3: A lookup that misses leaves `lk_ready` low. In the next cycle `mem_req` is high for exactly one cycle, with `mem_addr` equal to `ptbr` plus the zero-extended page number, both sampled in the cycle of the miss.
- R4: The walker waits for `mem_rsp_valid`, which may come any number of cycles after the request, and installs the returned frame in the following cycle. A lookup held steady through the walk is accepted in the cycle after the install, with the returned frame.
- R5: While any entry is invalid, a fill goes to the lowest-numbered invalid entry.
- R6: When every entry is valid, a fill replaces the entry under a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, on every install.
- R7: A high `flush` invalidates every entry at the next clock edge. An install that falls in the same cycle as a flush is discarded, so the held lookup misses again and starts a new fetch.
- R8: After reset every entry is invalid, the walker is idle, the pointer is 0 and `mem_req` is low.
- R9: While a miss is being handled, `lk_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| cur_pid | input | PID_W (4) | Identifier of the running process |
| ptbr | input | ADDR_W (12) | Base address of the page table |
| lk_valid | input | 1 | Lookup request present |
| lk_page | input | PAGE_W (4) | Page number to translate |
| lk_ready | output | 1 | Lookup accepted, frame valid |
| lk_frame | output | FRAME_W (8) | Translated frame number |
| mem_req | output | 1 | One-cycle page-table read request |
| mem_addr | output | ADDR_W (12) | Page-table read address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_frame | input | FRAME_W (8) | Frame number returned by the read |

## Verification
An install and a flush can fall in the same clock cycle. That is the one case where two state changes compete for the entry valid bits. The bench provokes it by raising `flush` in exactly the cycle after the memory response, while the walker is writing. It judges the result at the ports: the held lookup must stay not-ready and a second `mem_req` must follow, and the refetched translation must then be accepted. The replacement sequence is checked the same way, by looking up evicted and surviving translations after the buffer has wrapped.

// File: rtl/pid_tlb_pkg.sv
// Shared types of the translation cache.
// Assumes: nothing beyond IEEE 1800-2017.
package pid_tlb_pkg;
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_FETCH = 2'd1,
        WK_WAIT  = 2'd2,
        WK_FILL  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/tlb_store.sv
// Entry array with a parallel compare on process identifier and page number.
// Assumes at most one entry matches a given (pid, page) pair; the walker only
// installs a pair after a miss on it, so duplicates do not arise.
module tlb_store #(
    parameter int N       = 8,
    parameter int PID_W   = 4,
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 8,
    localparam int IDX_W  = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [PID_W-1:0]   q_pid,
    input  logic [PAGE_W-1:0]  q_page,
    output logic               hit,
    output logic [FRAME_W-1:0] hit_frame,
    output logic [N-1:0]       valid_vec,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic [FRAME_W-1:0] wr_frame
);
    logic [N-1:0]       vld;
    logic [PID_W-1:0]   e_pid   [N];
    logic [PAGE_W-1:0]  e_page  [N];
    logic [FRAME_W-1:0] e_frame [N];
    logic [N-1:0]       match;

    // Valid bits: cleared by reset or flush, set by an install.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    // Entry contents: written on install, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            e_pid[wr_idx]   <= wr_pid;
            e_page[wr_idx]  <= wr_page;
            e_frame[wr_idx] <= wr_frame;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (e_pid[i] == q_pid) && (e_page[i] == q_page);
    end

    // Frame mux: OR of the matching entries' frames.
    always_comb begin
        hit_frame = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_frame = hit_frame | e_frame[i];
        end
    end

    assign hit       = |match;
    assign valid_vec = vld;
endmodule

// File: rtl/tlb_victim.sv
// Picks the entry for the next install: lowest invalid entry, else the
// round-robin pointer. The pointer advances on every install.
// Assumes adv is high only in the cycle an install takes effect.
module tlb_victim #(
    parameter int N      = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic             adv,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr;

    // Victim choice: scan from the top so the lowest invalid index wins.
    always_comb begin
        victim = rr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim = IDX_W'(i);
        end
    end

    // Round-robin pointer with wrap at N.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr <= '0;
        end else if (adv) begin
            rr <= (rr == IDX_W'(N - 1)) ? '0 : rr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_walker.sv
// Miss handler: captures a missing lookup, issues one page-table read at
// base + page, waits for the response and installs it.
// Assumes the memory returns exactly one response per request.
module tlb_walker
    import pid_tlb_pkg::*;
#(
    parameter int PID_W   = 4,
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 8,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               lk_valid,
    input  logic               hit,
    input  logic [PID_W-1:0]   cur_pid,
    input  logic [PAGE_W-1:0]  lk_page,
    input  logic [ADDR_W-1:0]  ptbr,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [FRAME_W-1:0] mem_rsp_frame,
    output logic               fill_en,
    output logic [PID_W-1:0]   fill_pid,
    output logic [PAGE_W-1:0]  fill_page,
    output logic [FRAME_W-1:0] fill_frame,
    output logic               idle
);
    walk_state_e state;

    // Walk sequencing through fetch, wait and fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WK_IDLE;
        end else begin
            unique case (state)
                WK_IDLE:  if (lk_valid && !hit && !flush) state <= WK_FETCH;
                WK_FETCH: state <= WK_WAIT;
                WK_WAIT:  if (mem_rsp_valid) state <= WK_FILL;
                WK_FILL:  state <= WK_IDLE;
                default:  state <= WK_IDLE;
            endcase
        end
    end

    // Capture of the missing lookup and the read address.
    always_ff @(posedge clk) begin
        if (state == WK_IDLE && lk_valid && !hit) begin
            fill_pid  <= cur_pid;
            fill_page <= lk_page;
            mem_addr  <= ptbr + ADDR_W'(lk_page);
        end
    end

    // Capture of the returned frame.
    always_ff @(posedge clk) begin
        if (state == WK_WAIT && mem_rsp_valid) fill_frame <= mem_rsp_frame;
    end

    assign mem_req = (state == WK_FETCH);
    assign fill_en = (state == WK_FILL) && !flush;
    assign idle    = (state == WK_IDLE);
endmodule

// File: rtl/pid_tlb.sv
// Top of the process-tagged translation cache: entry store, victim choice
// and miss walker. Assumes the requester holds lk_valid, lk_page and cur_pid
// steady until lk_ready.
module pid_tlb #(
    parameter int N       = 8,
    parameter int PID_W   = 4,
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 8,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [PID_W-1:0]   cur_pid,
    input  logic [ADDR_W-1:0]  ptbr,
    input  logic               lk_valid,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic               lk_ready,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [FRAME_W-1:0] mem_rsp_frame
);
    logic               hit;
    logic [N-1:0]       valid_vec;
    logic               fill_en;
    logic [IDX_W-1:0]   victim;
    logic [PID_W-1:0]   fill_pid;
    logic [PAGE_W-1:0]  fill_page;
    logic [FRAME_W-1:0] fill_frame;
    logic               walk_idle;

    tlb_store #(.N(N), .PID_W(PID_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .q_pid(cur_pid), .q_page(lk_page),
        .hit(hit), .hit_frame(lk_frame), .valid_vec(valid_vec),
        .wr_en(fill_en), .wr_idx(victim),
        .wr_pid(fill_pid), .wr_page(fill_page), .wr_frame(fill_frame)
    );

    tlb_victim #(.N(N)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
        .adv(fill_en), .victim(victim)
    );

    tlb_walker #(.PID_W(PID_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .hit(hit), .cur_pid(cur_pid), .lk_page(lk_page),
        .ptbr(ptbr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_frame(mem_rsp_frame),
        .fill_en(fill_en), .fill_pid(fill_pid), .fill_page(fill_page),
        .fill_frame(fill_frame), .idle(walk_idle)
    );

    assign lk_ready = walk_idle && lk_valid && hit;
endmodule

// File: rtl/pid_tlb_chk.sv
// Temporal checks on the translation cache, bound into every pid_tlb.
module pid_tlb_chk #(
    parameter int PAGE_W = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              lk_valid,
    input logic [PAGE_W-1:0] lk_page,
    input logic              lk_ready,
    input logic [ADDR_W-1:0] ptbr,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              walk_idle
);
    // R1: acceptance only for a present request with the walker idle
    a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ready |-> (lk_valid && walk_idle));

    // R3: a miss leads to a request at base plus page in the next cycle
    a_r3_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_idle && lk_valid && !lk_ready && !flush) |=>
        (mem_req && mem_addr == $past(ptbr) + ADDR_W'($past(lk_page))));

    // R3: the request is a single-cycle pulse
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R7: nothing hits in the cycle after a flush
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_ready);

    // R9: no acceptance while a walk is in progress
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !lk_ready);
endmodule

bind pid_tlb pid_tlb_chk #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_page(lk_page), .lk_ready(lk_ready), .ptbr(ptbr), .mem_req(mem_req),
    .mem_addr(mem_addr), .walk_idle(walk_idle)
);

// File: tb/pid_tlb_bench.sv
`timescale 1ns/1ps
module pid_tlb_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic [3:0] cur_pid = '0;
    logic [11:0] ptbr = '0;
    logic       lk_valid = 1'b0;
    logic [3:0] lk_page = '0;
    logic       lk_ready;
    logic [7:0] lk_frame;
    logic       mem_req;
    logic [11:0] mem_addr;
    logic       mem_rsp_valid = 1'b0;
    logic [7:0] mem_rsp_frame = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pid_tlb u_pid_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cur_pid(cur_pid), .ptbr(ptbr),
        .lk_valid(lk_valid), .lk_page(lk_page), .lk_ready(lk_ready), .lk_frame(lk_frame),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_frame(mem_rsp_frame)
    );

    // Rows {expect_hit, pid, page}; each process's table sits at pid*16.
    localparam logic [8:0] VEC [21] = '{
        9'h013, 9'h113, 9'h023, 9'h015, 9'h123, 9'h115, 9'h016,
        9'h017, 9'h018, 9'h019, 9'h01A, 9'h01B, 9'h013, 9'h023,
        9'h116, 9'h11B, 9'h015, 9'h016, 9'h118, 9'h017, 9'h018
    };

    function automatic logic [7:0] table_frame(input logic [11:0] a);
        return a[7:0] * 8'd13 + 8'd7;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // One full memory response: called at the negedge after mem_req was seen.
    task automatic answer(input logic [11:0] addr);
        mem_rsp_valid = 1'b1;
        mem_rsp_frame = table_frame(addr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    // Lookup starting just after a negedge with the walker idle.
    task automatic lookup(input logic [3:0] pid, input logic [3:0] pg, input bit exp_hit,
                          input bit flush_fill, input string tag);
        logic [11:0] a;
        a = {4'h0, pid, 4'h0} + {8'h0, pg};
        cur_pid = pid; ptbr = {4'h0, pid, 4'h0}; lk_page = pg; lk_valid = 1'b1;
        #1;
        if (exp_hit) begin
            chk(lk_ready == 1'b1, {"R1 hit ", tag}, lk_ready, 1);
            chk(lk_frame == table_frame(a), {"R1 frame ", tag}, lk_frame, table_frame(a));
        end else begin
            chk(lk_ready == 1'b0, {"R3 miss ", tag}, lk_ready, 0);
            @(negedge clk);
            chk(mem_req && mem_addr == a, {"R3 request ", tag}, mem_addr, a);
            @(negedge clk);
            chk(mem_req == 1'b0, {"R3 pulse ", tag}, mem_req, 0);
            answer(a);
            chk(lk_ready == 1'b0, {"R9 busy ", tag}, lk_ready, 0);
            if (flush_fill) flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
            #1;
            if (flush_fill) begin
                chk(lk_ready == 1'b0, {"R7 fill dropped ", tag}, lk_ready, 0);
                @(negedge clk);
                chk(mem_req && mem_addr == a, {"R7 refetch ", tag}, mem_addr, a);
                @(negedge clk);
                answer(a);
                @(negedge clk);
                #1;
            end
            chk(lk_ready == 1'b1, {"R4 after fill ", tag}, lk_ready, 1);
            chk(lk_frame == table_frame(a), {"R4 frame ", tag}, lk_frame, table_frame(a));
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: idle after reset
        chk(mem_req == 1'b0, "R8 no request", mem_req, 0);
        chk(lk_ready == 1'b0, "R8 not ready", lk_ready, 0);

        // Table walk: R5 early fills into free entries, R6 wraps, R2 pid rows.
        for (int i = 0; i < 21; i++) begin
            string tag;
            if (i == 2 || i == 4 || i == 13) tag = "R2";
            else if (i >= 11) tag = "R6";
            else if (VEC[i][8]) tag = "R1";
            else tag = "R5";
            lookup(VEC[i][7:4], VEC[i][3:0], VEC[i][8], 1'b0, tag);
        end

        // R7: flush removes a resident translation.
        lookup(4'd1, 4'd8, 1'b1, 1'b0, "R7 pre");
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup(4'd1, 4'd8, 1'b0, 1'b0, "R7 post");

        // R7: flush in the install cycle discards the install.
        lookup(4'd1, 4'd12, 1'b0, 1'b1, "R7 collide");
        lookup(4'd1, 4'd12, 1'b1, 1'b0, "R7 kept");

        // R8: reset drops everything cached.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_req == 1'b0, "R8 no request after reset", mem_req, 0);
        @(negedge clk);
        lookup(4'd1, 4'd12, 1'b0, 1'b0, "R8 miss after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule